// File: doc/BRIEF.md
# Dual-Channel Converter Write Sequencer

This block turns write requests from on-chip logic into timed write cycles on an 8-bit parallel bus that feeds a converter with two input latches. Each request carries a data byte and a one-bit channel select. The bus has a shared data byte, an active-low chip select, an active-low write strobe and a channel-select line. The latch picked by the channel line follows the data while chip select and write are both low. It keeps its value once either line goes high.

Every bus cycle is built to meet minimum times measured against the rising edge of the write strobe. Chip select, channel select and data each have their own setup time. Channel select and data also have hold times, and the strobe has a minimum low width. All of these are parameters given in picoseconds, next to a clock-period parameter. Each one becomes a whole number of cycles, rounded up, and any nonzero time takes at least one cycle. Requests arrive through a valid/ready handshake. The block also keeps a shadow copy of the last byte committed to each channel.

Top module: `dac_pair_writer`

## Requirements
- R1: While reset is high and in the first cycle after it, bus_cs_n and bus_wr_n are 1, req_ready is 1, and bus_data, shadow_a and shadow_b are 0.
- R2: bus_chan = 0 addresses channel A and bus_chan = 1 addresses channel B. A request with req_chan = 0 lands in channel A only, and one with req_chan = 1 lands in channel B only.
- R3: bus_cs_n is low for at least ceil(T_CS_SETUP_PS / CLK_PERIOD_PS) cycles before bus_wr_n rises. When the chip-select hold time is zero, bus_cs_n rises on the same edge as bus_wr_n.
- R4: Each low pulse of bus_wr_n lasts at least ceil(T_WR_PULSE_PS / CLK_PERIOD_PS) cycles. bus_wr_n is low only while bus_cs_n is low.
- R5: bus_data and bus_chan are stable for their setup counts before bus_wr_n rises and for at least their hold counts after it: 7 and 3 cycles for data, 13 and 3 cycles for channel select at the default parameters.
- R6: req_ready is low from the cycle after a request is accepted until the hold window ends. With the default parameters this is 17 cycles (1 + 13 + 3). req_ready is never high while bus_cs_n is low.
- R7: When idle, bus_cs_n and bus_wr_n stay at 1. Changes on req_data and req_chan while req_valid is 0 leave bus_data, bus_chan, both shadows and both converter latches unchanged.
- R8: A channel's shadow register takes the new byte on the edge where bus_wr_n rises. The other channel's shadow register is not changed.
- R9: A request held valid while a cycle is in progress is accepted on the first cycle req_ready is high. Writes to alternating channels can follow one another back to back.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Write request present |
| req_ready | output | 1 | Sequencer can accept a request |
| req_data | input | DATA_W | Byte to write |
| req_chan | input | 1 | Target channel: 0 = A, 1 = B |
| bus_data | output | DATA_W | Shared data byte to the converter |
| bus_cs_n | output | 1 | Active-low chip select |
| bus_wr_n | output | 1 | Active-low write strobe |
| bus_chan | output | 1 | Channel-select line: 0 = A, 1 = B |
| shadow_a | output | DATA_W | Last byte committed to channel A |
| shadow_b | output | DATA_W | Last byte committed to channel B |

## Verification
A table of writes is applied first. It covers both channels, all-zero and all-one bytes, bytes with a single high bit at either end, and repeated writes to the same channel. These show whether the channel mapping is right and whether data bits are swapped or stuck. A bus-side latch model checks every setup, hold and pulse width in cycles, and its captured values are compared with the shadows. This catches a strobe that is too short or a data bus that moves too early. Separate directed runs cover input changes while the block is idle, and back-to-back writes to alternating channels. Those runs show whether the handshake accepts requests at the right moment.

// File: rtl/dacw_pkg.sv
package dacw_pkg;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_SETUP  = 2'd1,
    ST_STROBE = 2'd2,
    ST_HOLD   = 2'd3
  } seq_state_t;

  // minimum time in ps -> clock cycles, rounded up; zero stays zero
  function automatic int ps_to_cyc(input int t_ps, input int clk_ps);
    if (t_ps <= 0) return 0;
    return (t_ps + clk_ps - 1) / clk_ps;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/dacw_sequencer.sv
module dacw_sequencer #(
  parameter int LOW_CYC     = 13,
  parameter int HOLD_CYC    = 3,
  parameter int CS_HOLD_CYC = 0,
  parameter int CNT_W       = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic req_valid,
  output logic req_ready,
  output logic load_o,
  output logic commit_o,
  output logic cs_n_o,
  output logic wr_n_o
);
  import dacw_pkg::*;

  seq_state_t       st;
  logic [CNT_W-1:0] cnt;
  logic             strobe_last;
  logic             hold_last;

  assign req_ready   = (st == ST_IDLE);
  assign load_o      = req_valid && req_ready;
  assign strobe_last = (st == ST_STROBE) && (cnt == CNT_W'(LOW_CYC - 1));
  assign hold_last   = (st == ST_HOLD) && (cnt == CNT_W'(HOLD_CYC - 1));
  assign commit_o    = strobe_last;

  always_ff @(posedge clk) begin
    if (rst) begin
      st     <= ST_IDLE;
      cnt    <= '0;
      cs_n_o <= 1'b1;
      wr_n_o <= 1'b1;
    end else begin
      case (st)
        ST_IDLE: begin
          if (load_o) begin
            st     <= ST_SETUP;
            cs_n_o <= 1'b0;
            cnt    <= '0;
          end
        end
        ST_SETUP: begin
          st     <= ST_STROBE;
          wr_n_o <= 1'b0;
          cnt    <= '0;
        end
        ST_STROBE: begin
          if (strobe_last) begin
            st     <= ST_HOLD;
            wr_n_o <= 1'b1;
            cnt    <= '0;
            cs_n_o <= (CS_HOLD_CYC == 0);
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_HOLD: begin
          if (int'(cnt) + 1 >= CS_HOLD_CYC) cs_n_o <= 1'b1;
          if (hold_last) begin
            st  <= ST_IDLE;
            cnt <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  assert_wr_in_cs_R4: assert property (@(posedge clk) disable iff (rst)
    !wr_n_o |-> !cs_n_o);

  assert_cs_release_R3: assert property (@(posedge clk) disable iff (rst)
    ($rose(wr_n_o) && (CS_HOLD_CYC == 0)) |-> cs_n_o);

endmodule

// File: rtl/dacw_bus_regs.sv
module dacw_bus_regs #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [DATA_W-1:0] in_data,
  input  logic              in_chan,
  input  logic              cs_n,
  output logic [DATA_W-1:0] bus_data,
  output logic              bus_chan
);

  // values are only replaced on acceptance; otherwise they persist
  always_ff @(posedge clk) begin
    if (rst) begin
      bus_data <= '0;
      bus_chan <= 1'b0;
    end else if (load) begin
      bus_data <= in_data;
      bus_chan <= in_chan;
    end
  end

  assert_bus_fixed_in_cs_R5: assert property (@(posedge clk) disable iff (rst)
    (!cs_n && $past(!cs_n)) |-> ($stable(bus_data) && $stable(bus_chan)));

endmodule

// File: rtl/dacw_shadow.sv
module dacw_shadow #(
  parameter int DATA_W = 8,
  parameter int NUM_CH = 2,
  localparam int CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              commit,
  input  logic [CH_W-1:0]   chan,
  input  logic [DATA_W-1:0] data,
  output logic [DATA_W-1:0] shadow_o [NUM_CH]
);

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    always_ff @(posedge clk) begin
      if (rst)                                   shadow_o[g] <= '0;
      else if (commit && (chan == CH_W'(g)))     shadow_o[g] <= data;
    end

    assert_shadow_only_on_commit_R8: assert property (@(posedge clk) disable iff (rst)
      !(commit && (chan == CH_W'(g))) |=> $stable(shadow_o[g]));
  end

endmodule

// File: rtl/dac_pair_writer.sv
module dac_pair_writer #(
  parameter int DATA_W          = 8,
  parameter int CLK_PERIOD_PS   = 4000,
  parameter int T_CS_SETUP_PS   = 50000,
  parameter int T_CS_HOLD_PS    = 0,
  parameter int T_SEL_SETUP_PS  = 50000,
  parameter int T_SEL_HOLD_PS   = 10000,
  parameter int T_DAT_SETUP_PS  = 25000,
  parameter int T_DAT_HOLD_PS   = 10000,
  parameter int T_WR_PULSE_PS   = 50000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [DATA_W-1:0] req_data,
  input  logic              req_chan,
  output logic [DATA_W-1:0] bus_data,
  output logic              bus_cs_n,
  output logic              bus_wr_n,
  output logic              bus_chan,
  output logic [DATA_W-1:0] shadow_a,
  output logic [DATA_W-1:0] shadow_b
);
  import dacw_pkg::*;

  localparam int CS_SET_C  = ps_to_cyc(T_CS_SETUP_PS,  CLK_PERIOD_PS);
  localparam int CS_HOLD_C = ps_to_cyc(T_CS_HOLD_PS,   CLK_PERIOD_PS);
  localparam int SEL_SET_C = ps_to_cyc(T_SEL_SETUP_PS, CLK_PERIOD_PS);
  localparam int SEL_HLD_C = ps_to_cyc(T_SEL_HOLD_PS,  CLK_PERIOD_PS);
  localparam int DAT_SET_C = ps_to_cyc(T_DAT_SETUP_PS, CLK_PERIOD_PS);
  localparam int DAT_HLD_C = ps_to_cyc(T_DAT_HOLD_PS,  CLK_PERIOD_PS);
  localparam int WR_LOW_C  = ps_to_cyc(T_WR_PULSE_PS,  CLK_PERIOD_PS);
  localparam int LOW_CYC   = imax(imax(imax(WR_LOW_C, CS_SET_C),
                                       imax(SEL_SET_C, DAT_SET_C)), 1);
  localparam int HOLD_CYC  = imax(imax(SEL_HLD_C, DAT_HLD_C), imax(CS_HOLD_C, 1));
  localparam int CNT_W     = $clog2(imax(LOW_CYC, HOLD_CYC) + 1);
  localparam int RUN_W     = CNT_W + 2;

  logic              load;
  logic              commit;
  logic [DATA_W-1:0] shadow [2];

  dacw_sequencer #(
    .LOW_CYC    (LOW_CYC),
    .HOLD_CYC   (HOLD_CYC),
    .CS_HOLD_CYC(CS_HOLD_C),
    .CNT_W      (CNT_W)
  ) u_seq (
    .clk      (clk),
    .rst      (rst),
    .req_valid(req_valid),
    .req_ready(req_ready),
    .load_o   (load),
    .commit_o (commit),
    .cs_n_o   (bus_cs_n),
    .wr_n_o   (bus_wr_n)
  );

  dacw_bus_regs #(.DATA_W(DATA_W)) u_bus (
    .clk     (clk),
    .rst     (rst),
    .load    (load),
    .in_data (req_data),
    .in_chan (req_chan),
    .cs_n    (bus_cs_n),
    .bus_data(bus_data),
    .bus_chan(bus_chan)
  );

  dacw_shadow #(.DATA_W(DATA_W), .NUM_CH(2)) u_shadow (
    .clk     (clk),
    .rst     (rst),
    .commit  (commit),
    .chan    (bus_chan),
    .data    (bus_data),
    .shadow_o(shadow)
  );

  assign shadow_a = shadow[0];
  assign shadow_b = shadow[1];

  // run-length counters used by the timing assertions below
  logic [RUN_W-1:0] cs_run;
  logic [RUN_W-1:0] wr_run;

  always_ff @(posedge clk) begin
    if (rst) begin
      cs_run <= '0;
      wr_run <= '0;
    end else begin
      if (bus_cs_n)       cs_run <= '0;
      else if (~&cs_run)  cs_run <= cs_run + 1'b1;
      if (bus_wr_n)       wr_run <= '0;
      else if (~&wr_run)  wr_run <= wr_run + 1'b1;
    end
  end

  assert_cs_setup_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(bus_wr_n) |-> (cs_run >= RUN_W'(CS_SET_C)));

  assert_strobe_width_R4: assert property (@(posedge clk) disable iff (rst)
    $rose(bus_wr_n) |-> (wr_run >= RUN_W'(WR_LOW_C)));

  assert_busy_bus_steady_R5: assert property (@(posedge clk) disable iff (rst)
    (!req_ready && $past(!req_ready)) |-> ($stable(bus_data) && $stable(bus_chan)));

  assert_no_ready_in_cycle_R6: assert property (@(posedge clk) disable iff (rst)
    !bus_cs_n |-> !req_ready);

endmodule

// File: tb/test_dac_pair_writer.sv
module test_dac_pair_writer;

  localparam int CLK_PS = 4000;
  function automatic int cyc(input int t);
    return (t == 0) ? 0 : (t + CLK_PS - 1) / CLK_PS;
  endfunction
  localparam int CS_SET  = cyc(50000);
  localparam int SEL_SET = cyc(50000);
  localparam int SEL_HLD = cyc(10000);
  localparam int DAT_SET = cyc(25000);
  localparam int DAT_HLD = cyc(10000);
  localparam int WR_MIN  = cyc(50000);
  localparam int BUSY    = 1 + 13 + 3;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       req_valid = 1'b0;
  logic       req_ready;
  logic [7:0] req_data = 8'h00;
  logic       req_chan = 1'b0;
  logic [7:0] bus_data;
  logic       bus_cs_n, bus_wr_n, bus_chan;
  logic [7:0] shadow_a, shadow_b;

  always #2 clk = ~clk;

  dac_pair_writer #(
    .DATA_W(8), .CLK_PERIOD_PS(CLK_PS),
    .T_CS_SETUP_PS(50000), .T_CS_HOLD_PS(0),
    .T_SEL_SETUP_PS(50000), .T_SEL_HOLD_PS(10000),
    .T_DAT_SETUP_PS(25000), .T_DAT_HOLD_PS(10000),
    .T_WR_PULSE_PS(50000)
  ) i_dac_pair_writer (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_data(req_data), .req_chan(req_chan), .bus_data(bus_data),
    .bus_cs_n(bus_cs_n), .bus_wr_n(bus_wr_n), .bus_chan(bus_chan),
    .shadow_a(shadow_a), .shadow_b(shadow_b)
  );

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // converter latch model and bus timing monitor, sampled at falling edges
  logic [7:0] latch_a = 8'h00, latch_b = 8'h00;
  logic [7:0] p_data = 8'h00;
  logic       p_chan = 1'b0, p_wr = 1'b1, p_cs = 1'b1;
  int cs_run = 0, wr_run = 0, data_run = 0, chan_run = 0;
  int since_rise = 1000;
  int viol = 0;

  always @(negedge clk) begin
    if (rst) begin
      p_data = bus_data; p_chan = bus_chan; p_wr = bus_wr_n; p_cs = bus_cs_n;
      since_rise = 1000;
    end else begin
      if (since_rise < 1000) since_rise++;
      if (!p_wr && bus_wr_n) begin
        if (cs_run < CS_SET)    begin viol++; $display("R3 cs setup short %0d", cs_run); end
        if (wr_run < WR_MIN)    begin viol++; $display("R4 strobe short %0d", wr_run); end
        if (chan_run < SEL_SET) begin viol++; $display("R5 chan setup short %0d", chan_run); end
        if (data_run < DAT_SET) begin viol++; $display("R5 data setup short %0d", data_run); end
        since_rise = 0;
      end
      if (bus_data != p_data) begin
        if (since_rise < DAT_HLD) begin viol++; $display("R5 data hold short %0d", since_rise); end
        data_run = 1;
      end else data_run++;
      if (bus_chan != p_chan) begin
        if (since_rise < SEL_HLD) begin viol++; $display("R5 chan hold short %0d", since_rise); end
        chan_run = 1;
      end else chan_run++;
      cs_run = bus_cs_n ? 0 : cs_run + 1;
      wr_run = bus_wr_n ? 0 : wr_run + 1;
      if (!bus_wr_n && bus_cs_n) begin viol++; $display("R4 strobe outside select"); end
      if (!bus_cs_n && !bus_wr_n) begin
        if (bus_chan) latch_b = bus_data; else latch_a = bus_data;
      end
      p_data = bus_data; p_chan = bus_chan; p_wr = bus_wr_n; p_cs = bus_cs_n;
    end
  end

  task automatic do_write(input logic ch, input logic [7:0] d, output int busy);
    @(negedge clk);
    req_chan = ch; req_data = d; req_valid = 1'b1;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    busy = 0;
    while (!req_ready) begin busy++; @(negedge clk); end
  endtask

  // {chan, data, expected shadow_a, expected shadow_b}
  localparam logic [24:0] VEC [8] = '{
    {1'b0, 8'h5A, 8'h5A, 8'h00},
    {1'b1, 8'hC3, 8'h5A, 8'hC3},
    {1'b0, 8'hFF, 8'hFF, 8'hC3},
    {1'b1, 8'h00, 8'hFF, 8'h00},
    {1'b1, 8'h81, 8'hFF, 8'h81},
    {1'b0, 8'h01, 8'h01, 8'h81},
    {1'b0, 8'h80, 8'h80, 8'h81},
    {1'b1, 8'h7E, 8'h80, 8'h7E}
  };

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int busy;
    logic [7:0] hd;
    logic       hc;
    repeat (3) @(negedge clk);
    // R1: during reset
    check(bus_cs_n == 1'b1 && bus_wr_n == 1'b1, "R1", "strobes in reset",
          {bus_cs_n, bus_wr_n}, 2'b11);
    check(req_ready == 1'b1, "R1", "ready in reset", req_ready, 1);
    check(bus_data == 8'h00 && shadow_a == 8'h00 && shadow_b == 8'h00, "R1",
          "data/shadows in reset", {bus_data, shadow_a, shadow_b}, 0);
    rst = 1'b0;
    @(negedge clk);
    check(bus_cs_n && bus_wr_n && req_ready, "R1", "after reset",
          {bus_cs_n, bus_wr_n, req_ready}, 3'b111);

    // table of writes
    for (int i = 0; i < 8; i++) begin
      do_write(VEC[i][24], VEC[i][23:16], busy);
      check(busy == BUSY, "R6", $sformatf("busy cycles vec %0d", i), busy, BUSY);
      check(shadow_a == VEC[i][15:8], "R8", $sformatf("shadow_a vec %0d", i),
            shadow_a, VEC[i][15:8]);
      check(shadow_b == VEC[i][7:0], "R8", $sformatf("shadow_b vec %0d", i),
            shadow_b, VEC[i][7:0]);
      check(latch_a == VEC[i][15:8] && latch_b == VEC[i][7:0], "R2",
            $sformatf("latches vec %0d", i), {latch_a, latch_b},
            {VEC[i][15:8], VEC[i][7:0]});
      check(bus_cs_n && bus_wr_n, "R7", $sformatf("idle strobes vec %0d", i),
            {bus_cs_n, bus_wr_n}, 2'b11);
      check(bus_data == VEC[i][23:16] && bus_chan == VEC[i][24], "R7",
            $sformatf("bus keeps last value vec %0d", i), {bus_chan, bus_data},
            {VEC[i][24], VEC[i][23:16]});
    end

    // R7: idle inputs with valid low have no effect
    hd = bus_data; hc = bus_chan;
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      req_data = 8'h11 * k[7:0]; req_chan = k[0];
    end
    @(negedge clk);
    check(bus_data == hd && bus_chan == hc, "R7", "bus after idle input churn",
          {bus_chan, bus_data}, {hc, hd});
    check(shadow_a == 8'h80 && shadow_b == 8'h7E, "R7", "shadows after idle churn",
          {shadow_a, shadow_b}, 16'h807E);
    check(latch_a == 8'h80 && latch_b == 8'h7E, "R7", "latches after idle churn",
          {latch_a, latch_b}, 16'h807E);
    check(bus_cs_n && bus_wr_n, "R7", "strobes idle", {bus_cs_n, bus_wr_n}, 2'b11);

    // R9: back-to-back, alternate channels
    @(negedge clk);
    req_chan = 1'b0; req_data = 8'h3C; req_valid = 1'b1;
    @(negedge clk);
    check(!req_ready, "R6", "ready drops after accept", req_ready, 0);
    req_chan = 1'b1; req_data = 8'hA5;
    busy = 0;
    while (!req_ready) begin busy++; @(negedge clk); end
    check(busy == BUSY, "R6", "first busy window", busy, BUSY);
    check(shadow_a == 8'h3C && shadow_b == 8'h7E, "R9", "first of pair landed",
          {shadow_a, shadow_b}, 16'h3C7E);
    @(negedge clk);
    req_valid = 1'b0;
    check(!req_ready && bus_data == 8'hA5 && bus_chan == 1'b1, "R9",
          "second accepted at first ready", {req_ready, bus_chan, bus_data}, {2'b01, 8'hA5});
    while (!req_ready) @(negedge clk);
    check(shadow_a == 8'h3C && shadow_b == 8'hA5, "R9", "pair shadows",
          {shadow_a, shadow_b}, 16'h3CA5);
    check(latch_a == 8'h3C && latch_b == 8'hA5, "R2", "pair latches",
          {latch_a, latch_b}, 16'h3CA5);

    // R3 R4 R5: timing monitor results
    check(viol == 0, "R3", "bus timing violations (R4 R5 as well)", viol, 0);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule